// File: doc/BRIEF.md
# Decimal Fractional Clock Divider

This block derives a slower clock from a fast one when the wanted ratio is not a whole number. The ratio has the form K = N + X/B. B is a decimal base, either 10 or 100, so the fraction carries one or two decimal digits. Each output period lasts either N or N+1 input cycles. A decimal accumulator picks the longer period exactly X times in every frame of B periods and spreads those long periods as evenly as it can. This keeps the phase error between the divided clock and an ideal clock of ratio K below one input cycle.

Software or a neighbouring block drives the integer part, the fractional numerator and the base select. The divider copies them in during reset and afterwards only at the point where a frame of B periods wraps, so each frame uses one consistent setting. The divided clock is high for the first half of each period, rounded down, and low for the rest. The modulus flag shows which length the current period uses.

Top module: `decimal_frac_divider`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, the divided clock is high and the counter sits at the start of a period with the accumulator at zero. With X > 0 the first period after reset is N+1 cycles long.
- R2: The modulus flag reads 1 while the current period lasts N cycles and 0 while it lasts N+1 cycles. During reset it reads 1 exactly when X = 0.
- R3: Each period, the value B − X is added to the accumulator. If the new sum is less than B, that period is long (N+1) and the sum is kept. Otherwise the period is short (N) and B is subtracted from the sum. Both the period length and the accumulator change only when a period ends.
- R4: With N = 8, X = 7 and B = 10, the period lengths after reset run 9,9,9,8,9,9,8,9,9,8 and this pattern repeats.
- R5: Every frame of B periods takes exactly N·B + X input cycles and contains exactly X long periods. The accumulator is back at zero when the frame wraps.
- R6: The base select input picks B = 10 when it is 0 and B = 100 when it is 1.
- R7: With X = 0, every period is N cycles long and the modulus flag stays 1.
- R8: In a period of L cycles, the divided clock is high for floor(L/2) cycles and then low for the remaining cycles. Every period starts high.
- R9: A change of N, X or the base select has no effect until the current frame wraps. At that wrap the block loads the values present on the inputs.
- R10: The accumulator always stays below B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high; also loads the setting |
| div_int | input | 8 | Integer part N of the ratio, N ≥ 2 |
| div_frac | input | 7 | Fractional numerator X, X < B |
| frac_wide | input | 1 | Base select: 0 gives B = 10, 1 gives B = 100 |
| clk_out | output | 1 | Divided clock |
| mod_sel | output | 1 | 1 = current period is N cycles, 0 = N+1 cycles |

## Verification
Two events can fall on the same input cycle: the last period of a frame ends and the accumulator decision is made, and new setting values are loaded at the frame wrap. The bench provokes this by changing N, X and the base in the middle of a frame, in both directed and seeded random runs. It then checks that every remaining period of the old frame still follows the old ratio, and that the first period of the new frame already follows the new one. Each period is judged against a model in the bench, cycle by cycle, for both the waveform and the modulus flag. Frame totals are also measured from the rising edges of the divided clock.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

    localparam int NW       = 8;          // integer part width
    localparam int XW       = 7;          // fractional numerator width
    localparam int BASE_LO  = 10;
    localparam int BASE_HI  = 100;
    localparam int AW       = $clog2(2 * BASE_HI);   // holds sums up to 2*B-1
    localparam int LW       = NW + 1;     // period length width (N+1)

    typedef struct packed {
        logic [NW-1:0] n;
        logic [XW-1:0] x;
        logic [AW-1:0] base;
    } cfg_t;

    typedef enum logic {
        MOD_LONG  = 1'b0,
        MOD_SHORT = 1'b1
    } mod_e;

    function automatic logic [AW-1:0] base_of(input logic wide);
        return wide ? AW'(BASE_HI) : AW'(BASE_LO);
    endfunction

endpackage

// File: rtl/fdiv_cfg.sv
module fdiv_cfg
    import fdiv_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [NW-1:0] n_in,
    input  logic [XW-1:0] x_in,
    input  logic          wide_in,
    input  logic          period_end,
    output cfg_t          cfg,
    output logic          frame_last
);

    logic [AW-1:0] idx;
    cfg_t          cfg_new;

    assign cfg_new    = '{n: n_in, x: x_in, base: base_of(wide_in)};
    assign frame_last = (idx == cfg.base - AW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= cfg_new;
            idx <= '0;
        end else if (period_end) begin
            if (frame_last) begin
                cfg <= cfg_new;
                idx <= '0;
            end else begin
                idx <= idx + AW'(1);
            end
        end
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(period_end && frame_last) |=> $stable(cfg)); // R9

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        idx < cfg.base); // R5

endmodule

// File: rtl/fdiv_accum.sv
module fdiv_accum
    import fdiv_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          period_end,
    input  logic          frame_last,
    input  logic [XW-1:0] x_i,
    input  logic [AW-1:0] base_i,
    output logic          long_sel
);

    logic [AW-1:0] acc;
    logic [AW-1:0] sum;
    logic [AW-1:0] acc_nxt;

    always_comb begin
        sum      = acc + (base_i - AW'(x_i));
        long_sel = (sum < base_i);
        acc_nxt  = long_sel ? sum : (sum - base_i);
    end

    always_ff @(posedge clk) begin
        if (rst)             acc <= '0;
        else if (period_end) acc <= acc_nxt;
    end

    AST_ACC_BOUND: assert property (@(posedge clk) disable iff (rst)
        acc < base_i); // R10

    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !period_end |=> $stable(acc)); // R3

    AST_FRAME_ZERO: assert property (@(posedge clk) disable iff (rst)
        (period_end && frame_last) |=> (acc == '0)); // R5

endmodule

// File: rtl/fdiv_period_cnt.sv
module fdiv_period_cnt
    import fdiv_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [LW-1:0] len,
    output logic          period_end,
    output logic          wave
);

    logic [LW-1:0] cnt;

    assign period_end = (cnt == len - LW'(1));
    assign wave       = (cnt < (len >> 1));

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (period_end) cnt <= '0;
        else                 cnt <= cnt + LW'(1);
    end

    AST_LEN_STEADY: assert property (@(posedge clk) disable iff (rst)
        !period_end |=> $stable(len)); // R3

    AST_START_HIGH: assert property (@(posedge clk) disable iff (rst)
        period_end |=> wave); // R8

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt < len); // R8

endmodule

// File: rtl/decimal_frac_divider.sv
module decimal_frac_divider
    import fdiv_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [NW-1:0] div_int,
    input  logic [XW-1:0] div_frac,
    input  logic          frac_wide,
    output logic          clk_out,
    output logic          mod_sel
);

    cfg_t          cfg;
    logic          frame_last;
    logic          period_end;
    logic          long_sel;
    logic [LW-1:0] len;
    mod_e          mod_q;

    fdiv_cfg u_cfg (
        .clk        (clk),
        .rst        (rst),
        .n_in       (div_int),
        .x_in       (div_frac),
        .wide_in    (frac_wide),
        .period_end (period_end),
        .cfg        (cfg),
        .frame_last (frame_last)
    );

    fdiv_accum u_accum (
        .clk        (clk),
        .rst        (rst),
        .period_end (period_end),
        .frame_last (frame_last),
        .x_i        (cfg.x),
        .base_i     (cfg.base),
        .long_sel   (long_sel)
    );

    assign len = LW'(cfg.n) + LW'(long_sel);

    fdiv_period_cnt u_cnt (
        .clk        (clk),
        .rst        (rst),
        .len        (len),
        .period_end (period_end),
        .wave       (clk_out)
    );

    assign mod_q   = long_sel ? MOD_LONG : MOD_SHORT;
    assign mod_sel = mod_q;

    AST_RESET_HIGH: assert property (@(posedge clk)
        $fell(rst) |-> clk_out); // R1

    AST_XZERO_SHORT: assert property (@(posedge clk) disable iff (rst)
        (cfg.x == '0) |-> mod_sel); // R7

endmodule

// File: tb/decimal_frac_divider_bench.sv
`timescale 1ns/1ps
module decimal_frac_divider_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] div_int;
    logic [6:0] div_frac;
    logic       frac_wide;
    logic       clk_out;
    logic       mod_sel;

    always #4 clk = ~clk;

    decimal_frac_divider u_decimal_frac_divider (
        .clk       (clk),
        .rst       (rst),
        .div_int   (div_int),
        .div_frac  (div_frac),
        .frac_wide (frac_wide),
        .clk_out   (clk_out),
        .mod_sel   (mod_sel)
    );

    int checks = 0;
    int fails  = 0;
    int m_n, m_x, m_base, m_acc, m_idx;
    int got [0:1023];
    int ngot;
    int run_len;
    bit prev_wave;
    bit done = 0;

    function automatic int base_f(input bit w);
        return w ? 100 : 10;
    endfunction

    function automatic bit long_f(input int acc, input int base, input int x);
        return (acc + base - x) < base;
    endfunction

    function automatic int seq87(input int i);
        case (i % 10)
            3, 6, 9: return 8;
            default: return 9;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input int n, input int x, input bit w);
        rst = 1'b1; div_int = 8'(n); div_frac = 7'(x); frac_wide = w;
        repeat (3) @(negedge clk);
        check(clk_out === 1'b1, "R1 reset clk_out", int'(clk_out), 1);
        check(mod_sel === (x == 0), "R2 reset mod_sel", int'(mod_sel), int'(x == 0));
        rst = 1'b0;
        m_n = n; m_x = x; m_base = base_f(w); m_acc = 0; m_idx = 0;
        ngot = 0; run_len = 0; prev_wave = 1'b0;
    endtask

    // runs k periods; at the first cycle of period chg_p the inputs change
    task automatic run_periods(input int k, input int chg_p, input int cn, input int cx, input bit cw);
        for (int p = 0; p < k; p++) begin
            bit lg = long_f(m_acc, m_base, m_x);
            int L  = m_n + (lg ? 1 : 0);
            bit wave_ok = 1'b1, mod_ok = 1'b1;
            int wact = 0, wexp = 0;
            for (int c = 0; c < L; c++) begin
                if (clk_out !== (c < L / 2)) begin
                    if (wave_ok) begin wact = int'(clk_out); wexp = int'(c < L / 2); end
                    wave_ok = 1'b0;
                end
                if (mod_sel !== !lg) mod_ok = 1'b0;
                if (clk_out && !prev_wave) begin
                    if (run_len > 0 && ngot < 1024) begin got[ngot] = run_len; ngot++; end
                    run_len = 0;
                end
                run_len++;
                prev_wave = clk_out;
                if (p == chg_p && c == 0) begin
                    div_int = 8'(cn); div_frac = 7'(cx); frac_wide = cw;
                end
                if (c == L - 1) begin
                    int s = m_acc + m_base - m_x;
                    m_acc = lg ? s : s - m_base;
                    if (m_idx == m_base - 1) begin
                        m_idx = 0;
                        m_n = int'(div_int); m_x = int'(div_frac); m_base = base_f(frac_wide);
                    end else begin
                        m_idx++;
                    end
                end
                @(negedge clk);
            end
            check(wave_ok, "R8 waveform in period", wact, wexp);
            check(mod_ok, "R3 modulus flag per accumulator rule", int'(mod_sel), int'(!lg));
        end
    endtask

    function automatic int sum_got(input int from, input int cnt);
        int s = 0;
        for (int i = from; i < from + cnt; i++) s += got[i];
        return s;
    endfunction

    function automatic int count_len(input int from, input int cnt, input int v);
        int s = 0;
        for (int i = from; i < from + cnt; i++) if (got[i] == v) s++;
        return s;
    endfunction

    initial begin
        rst = 1'b1; div_int = 8'd8; div_frac = 7'd7; frac_wide = 1'b0;

        // directed: ratio 8.7
        do_reset(8, 7, 1'b0);
        run_periods(21, -1, 0, 0, 1'b0);
        check(got[0] == 9, "R1 first period long", got[0], 9);
        for (int i = 0; i < 20; i++)
            check(got[i] == seq87(i), "R4 8.7 sequence", got[i], seq87(i));
        check(sum_got(0, 10) == 87, "R5 frame total 8.7", sum_got(0, 10), 87);
        check(count_len(0, 10, 9) == 7, "R5 long count 8.7", count_len(0, 10, 9), 7);

        // X = 0 gives plain divide by N
        do_reset(5, 0, 1'b0);
        run_periods(11, -1, 0, 0, 1'b0);
        for (int i = 0; i < 10; i++)
            check(got[i] == 5, "R7 integer divide", got[i], 5);

        // two-digit fraction, base 100
        do_reset(3, 37, 1'b1);
        run_periods(101, -1, 0, 0, 1'b0);
        check(sum_got(0, 100) == 337, "R6 base-100 frame total", sum_got(0, 100), 337);
        check(count_len(0, 100, 4) == 37, "R5 base-100 long count", count_len(0, 100, 4), 37);

        // smallest N with odd period
        do_reset(2, 5, 1'b0);
        run_periods(11, -1, 0, 0, 1'b0);
        check(sum_got(0, 10) == 25, "R6 base-10 frame total N=2", sum_got(0, 10), 25);

        // mid-frame change must wait for the wrap
        do_reset(8, 7, 1'b0);
        run_periods(21, 4, 4, 5, 1'b0);
        check(got[9] == 8, "R9 old setting until wrap", got[9], 8);
        check(sum_got(0, 10) == 87, "R9 old frame total", sum_got(0, 10), 87);
        check(sum_got(10, 10) == 45, "R9 new frame total", sum_got(10, 10), 45);

        // seeded random configurations and mid-run changes
        void'($urandom(32'h5EED1234));
        for (int r = 0; r < 8; r++) begin
            int  n  = 2 + int'($urandom % 19);
            bit  w  = bit'($urandom % 2);
            int  x  = int'($urandom % base_f(w));
            int  cn = 2 + int'($urandom % 19);
            bit  cw = bit'($urandom % 2);
            int  cx = int'($urandom % base_f(cw));
            int  np = 2 * base_f(w) + 1;
            int  cp = int'($urandom % (2 * base_f(w)));
            do_reset(n, x, w);
            run_periods(np, cp, cn, cx, cw);
            check(sum_got(0, base_f(w)) == n * base_f(w) + x, "R5 random frame total",
                  sum_got(0, base_f(w)), n * base_f(w) + x);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R8 watchdog expired: got 0 expected 1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule